// File: doc/BRIEF.md
# Mixed-Sign Multiplier

This block multiplies two operands under one of seven sign and width modes using a single signed 17-bit by 17-bit multiplication core. Each operand is widened to 17 bits before it reaches the core. Zero-extension makes the core treat an operand as unsigned, and sign-extension makes the core treat it as signed. The same array therefore serves signed, unsigned and mixed products, multiplication by a small unsigned literal, and a narrow byte-by-byte product.

A caller places two 16-bit operands, a 5-bit literal and a 3-bit mode code on the inputs and raises the strobe. By default the product is registered. It appears on the output one clock later with the valid flag set. Strobes may arrive on every cycle. When the strobe is low, the registered product holds its last value.

The one-stage output register is controlled by a two-state machine:
- `ST_IDLE` means no result is presented.
- `ST_HELD` means a fresh result is presented.

The transitions are as follows:
- *accept*: `ST_IDLE` to `ST_HELD` when the strobe is high.
- *stream*: `ST_HELD` to `ST_HELD` when the strobe is high.
- *drain*: `ST_HELD` to `ST_IDLE` when the strobe is low.
- *rest*: `ST_IDLE` to `ST_IDLE` when the strobe is low.

Setting `LATENCY` to 0 removes the register, and the block becomes combinational.

Top module: `mulx_unit`

## Requirements
- R1: `valid_o` is high exactly one clock after a cycle in which `start_i` was high. It is low one clock after a cycle in which `start_i` was low.
- R2: While `rst_i` is high (synchronous), `valid_o` and `prod_o` are cleared to zero.
- R3: Mode code 0 gives the product of `opa_i` signed and `opb_i` signed, as a 32-bit two's-complement value.
- R4: Mode code 1 gives the product of `opa_i` unsigned and `opb_i` unsigned.
- R5: Mode code 2 gives `opa_i` signed times `lit_i` unsigned. `lit_i` is zero-extended, and `opb_i` has no effect.
- R6: Mode code 3 gives `opa_i` unsigned times `opb_i` signed.
- R7: Mode code 4 gives `opa_i` signed times `opb_i` unsigned.
- R8: Mode code 5 gives `opa_i` unsigned times `lit_i` unsigned. Bits 31..21 of the product are therefore zero.
- R9: Mode code 6 gives `opa_i[7:0]` times `opb_i[7:0]`, both unsigned. Bits 15..8 of each operand have no effect, and bits 31..16 of the product are zero.
- R10: Mode code 7 is reserved. It gives a zero product, and `valid_o` is still asserted one clock after the strobe.
- R11: In a cycle with `start_i` low, `prod_o` keeps its previous value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Operand strobe |
| mode_i | input | 3 | Sign and width mode code |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| lit_i | input | 5 | Unsigned literal operand |
| prod_o | output | 32 | Product, low 32 bits of the core result |
| valid_o | output | 1 | Product valid |

## Verification
Two functions can fall in the same cycle:
- Presenting the result of one strobe.
- Capturing the operands and mode of the next strobe.

The bench holds the strobe high for a long back-to-back stream of 648 products, covering every mode code, corner operands and several literals. Each result is judged at the falling edge, while the next vector is already being driven. If a mode or operand leaked from the following vector, or the register missed a capture, a wrong product would be seen against the arithmetic reference. After the stream, the strobe is dropped with different operands on the inputs. The output must then show `valid_o` low and the last product held.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    typedef enum logic [2:0] {
        MD_SS   = 3'd0,
        MD_UU   = 3'd1,
        MD_SLIT = 3'd2,
        MD_US   = 3'd3,
        MD_SU   = 3'd4,
        MD_ULIT = 3'd5,
        MD_BYTE = 3'd6,
        MD_RSVD = 3'd7
    } mul_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } stage_e;

    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic b_lit;
        logic narrow;
        logic kill;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(input mul_mode_e m);
        mode_ctl_t c;
        c = '0;
        unique case (m)
            MD_SS:   begin c.a_sgn = 1'b1; c.b_sgn = 1'b1; end
            MD_UU:   ;
            MD_SLIT: begin c.a_sgn = 1'b1; c.b_lit = 1'b1; end
            MD_US:   c.b_sgn = 1'b1;
            MD_SU:   c.a_sgn = 1'b1;
            MD_ULIT: c.b_lit = 1'b1;
            MD_BYTE: c.narrow = 1'b1;
            MD_RSVD: c.kill = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mulx_opnd_ext.sv
module mulx_opnd_ext
    import mulx_pkg::*;
#(
    parameter int W        = 16,
    parameter int LIT_W    = 5,
    parameter int NARROW_W = 8
) (
    input  logic [W-1:0]     opa_i,
    input  logic [W-1:0]     opb_i,
    input  logic [LIT_W-1:0] lit_i,
    input  mode_ctl_t        ctl_i,
    output logic signed [W:0] a_x_o,
    output logic signed [W:0] b_x_o
);
    localparam int PAD_N = W - NARROW_W;
    localparam int PAD_L = W - LIT_W;

    logic [W-1:0] a_sel;
    logic [W-1:0] b_sel;

    always_comb begin
        if (ctl_i.narrow) begin
            a_sel = {{PAD_N{1'b0}}, opa_i[NARROW_W-1:0]};
            b_sel = {{PAD_N{1'b0}}, opb_i[NARROW_W-1:0]};
        end else if (ctl_i.b_lit) begin
            a_sel = opa_i;
            b_sel = {{PAD_L{1'b0}}, lit_i};
        end else begin
            a_sel = opa_i;
            b_sel = opb_i;
        end
    end

    // The 17th bit decides how the signed core reads each operand.
    assign a_x_o = {ctl_i.a_sgn & a_sel[W-1], a_sel};
    assign b_x_o = {ctl_i.b_sgn & b_sel[W-1], b_sel};

endmodule

// File: rtl/mulx_core.sv
module mulx_core #(
    parameter int CW    = 17,
    parameter int OUT_W = 32
) (
    input  logic signed [CW-1:0] a_i,
    input  logic signed [CW-1:0] b_i,
    output logic [OUT_W-1:0]     p_o
);
    // Signed array; only the low OUT_W bits of the full product are kept.
    logic signed [OUT_W-1:0] a_w;
    logic signed [OUT_W-1:0] b_w;

    assign a_w = OUT_W'(a_i);
    assign b_w = OUT_W'(b_i);
    assign p_o = a_w * b_w;

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int W        = 16,
    parameter int LIT_W    = 5,
    parameter int NARROW_W = 8,
    parameter int LATENCY  = 1,
    localparam int CW      = W + 1,
    localparam int PW      = 2 * W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    input  logic [W-1:0]     opa_i,
    input  logic [W-1:0]     opb_i,
    input  logic [LIT_W-1:0] lit_i,
    output logic [PW-1:0]    prod_o,
    output logic             valid_o
);
    mode_ctl_t        ctl;
    logic signed [W:0] a_x;
    logic signed [W:0] b_x;
    logic [PW-1:0]    core_p;
    logic [PW-1:0]    prod_c;

    assign ctl = decode_mode(mul_mode_e'(mode_i));

    mulx_opnd_ext #(
        .W(W), .LIT_W(LIT_W), .NARROW_W(NARROW_W)
    ) u_ext (
        .opa_i(opa_i),
        .opb_i(opb_i),
        .lit_i(lit_i),
        .ctl_i(ctl),
        .a_x_o(a_x),
        .b_x_o(b_x)
    );

    mulx_core #(
        .CW(CW), .OUT_W(PW)
    ) u_core (
        .a_i(a_x),
        .b_i(b_x),
        .p_o(core_p)
    );

    assign prod_c = ctl.kill ? '0 : core_p;

    generate
        if (LATENCY == 1) begin : g_reg
            stage_e        st_q;
            stage_e        st_d;
            logic [PW-1:0] prod_q;

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    ST_IDLE: if (start_i)  st_d = ST_HELD;
                    ST_HELD: if (!start_i) st_d = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) st_q <= ST_IDLE;
                else       st_q <= st_d;
            end

            always_ff @(posedge clk_i) begin
                if (rst_i)        prod_q <= '0;
                else if (start_i) prod_q <= prod_c;
            end

            assign prod_o  = prod_q;
            assign valid_o = (st_q == ST_HELD);
        end else begin : g_comb
            assign prod_o  = prod_c;
            assign valid_o = start_i;
        end
    endgenerate

endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
    parameter int W       = 16,
    parameter int LIT_W   = 5,
    parameter int LATENCY = 1,
    localparam int PW     = 2 * W
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          start_i,
    input logic [2:0]    mode_i,
    input logic [PW-1:0] prod_o,
    input logic          valid_o
);
    generate
        if (LATENCY == 1) begin : g_seq
            p_valid_rise_r1: assert property (@(posedge clk_i) disable iff (rst_i)
                start_i |=> valid_o);
            p_valid_fall_r1: assert property (@(posedge clk_i) disable iff (rst_i)
                !start_i |=> !valid_o);
            p_ulit_width_r8: assert property (@(posedge clk_i) disable iff (rst_i)
                (start_i && mode_i == 3'd5) |=> (prod_o[PW-1:W+LIT_W] == '0));
            p_byte_upper_r9: assert property (@(posedge clk_i) disable iff (rst_i)
                (start_i && mode_i == 3'd6) |=> (prod_o[PW-1:W] == '0));
            p_rsvd_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
                (start_i && mode_i == 3'd7) |=> (prod_o == '0 && valid_o));
            p_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
                !start_i |=> $stable(prod_o));
        end
    endgenerate

endmodule

bind mulx_unit mulx_unit_chk #(
    .W(W), .LIT_W(LIT_W), .LATENCY(LATENCY)
) u_chk (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .start_i(start_i),
    .mode_i(mode_i),
    .prod_o(prod_o),
    .valid_o(valid_o)
);

// File: tb/mulx_unit_tb_top.sv
`timescale 1ns/1ps
module mulx_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        start_i;
    logic [2:0]  mode_i;
    logic [15:0] opa_i;
    logic [15:0] opb_i;
    logic [4:0]  lit_i;
    logic [31:0] prod_o;
    logic        valid_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    mulx_unit dut_i (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .mode_i(mode_i),
        .opa_i(opa_i), .opb_i(opb_i), .lit_i(lit_i),
        .prod_o(prod_o), .valid_o(valid_o)
    );

    function automatic longint as_s(input logic [15:0] x);
        return x[15] ? longint'(x) - 65536 : longint'(x);
    endfunction

    function automatic longint as_u(input logic [15:0] x);
        return longint'(x);
    endfunction

    function automatic logic [31:0] expect_prod(input int m, input logic [15:0] a,
                                                input logic [15:0] b, input logic [4:0] l);
        longint r;
        case (m)
            0: r = as_s(a) * as_s(b);
            1: r = as_u(a) * as_u(b);
            2: r = as_s(a) * longint'(l);
            3: r = as_u(a) * as_s(b);
            4: r = as_s(a) * as_u(b);
            5: r = as_u(a) * longint'(l);
            6: r = longint'(a[7:0]) * longint'(b[7:0]);
            default: r = 0;
        endcase
        return r[31:0];
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [15:0] vals [9] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                              16'h8001, 16'hFFFF, 16'h5AA5, 16'h01FE};
    logic [4:0]  lits [4] = '{5'd0, 5'd1, 5'd16, 5'd31};

    initial begin
        logic [31:0] prev_exp;
        string       prev_tag;
        bit          have_prev;
        rst_i = 1'b1; start_i = 1'b0; mode_i = '0;
        opa_i = '0; opb_i = '0; lit_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", {31'd0, valid_o}, 32'd0);
        check("R2", prod_o, 32'd0);
        rst_i = 1'b0;

        // back-to-back stream over every mode and corner operand
        have_prev = 1'b0;
        prev_exp  = '0;
        prev_tag  = "";
        for (int m = 0; m < 8; m++) begin
            for (int ia = 0; ia < 9; ia++) begin
                for (int ib = 0; ib < 9; ib++) begin
                    if (have_prev) begin
                        check(prev_tag, prod_o, prev_exp);
                        check("R1", {31'd0, valid_o}, 32'd1);
                    end
                    start_i = 1'b1;
                    mode_i  = 3'(m);
                    opa_i   = vals[ia];
                    opb_i   = vals[ib];
                    lit_i   = lits[(ia + ib) % 4];
                    prev_exp  = expect_prod(m, vals[ia], vals[ib], lits[(ia + ib) % 4]);
                    prev_tag  = mode_tag(m);
                    have_prev = 1'b1;
                    @(negedge clk);
                end
            end
        end
        check(prev_tag, prod_o, prev_exp);
        check("R1", {31'd0, valid_o}, 32'd1);

        // strobe low with new operands: valid drops, product holds
        start_i = 1'b0; mode_i = 3'd1; opa_i = 16'h1234; opb_i = 16'h0101;
        @(negedge clk);
        check("R1", {31'd0, valid_o}, 32'd0);
        check("R11", prod_o, prev_exp);
        @(negedge clk);
        check("R11", prod_o, prev_exp);

        // single pulse after idle, then idle again
        start_i = 1'b1; mode_i = 3'd2; opa_i = 16'hFFFE; opb_i = 16'hFFFF; lit_i = 5'd7;
        @(negedge clk);
        start_i = 1'b0; opa_i = 16'h0003;
        check("R5", prod_o, 32'hFFFF_FFF2);
        check("R1", {31'd0, valid_o}, 32'd1);
        @(negedge clk);
        check("R1", {31'd0, valid_o}, 32'd0);
        check("R11", prod_o, 32'hFFFF_FFF2);

        // reserved code after a nonzero product
        start_i = 1'b1; mode_i = 3'd7; opa_i = 16'h7FFF; opb_i = 16'h7FFF;
        @(negedge clk);
        start_i = 1'b0;
        check("R10", prod_o, 32'd0);
        check("R10", {31'd0, valid_o}, 32'd1);

        // synchronous reset clears a live result
        start_i = 1'b1; mode_i = 3'd1; opa_i = 16'hFFFF; opb_i = 16'hFFFF;
        @(negedge clk);
        check("R4", prod_o, 32'hFFFE_0001);
        rst_i = 1'b1;
        @(negedge clk);
        check("R2", prod_o, 32'd0);
        check("R2", {31'd0, valid_o}, 32'd0);
        rst_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule